// File: doc/BRIEF.md
# Mailbox Receive Queue

This block is the receiving half of an inter-processor mailbox. Remote senders hand it messages over a valid/ready input port. Each message carries a 64-bit payload and a 3-bit source channel number. Accepted messages are kept in a circular queue of `DEPTH` entries. The local processor sees the oldest entry through a small register window. It reads the payload as two 32-bit halves and reads the channel number from its own register. It then removes the entry by writing a pop command.

Software does not get a fill count. It gets the raw read and write positions and a full flag, and works out the occupancy from those. When both positions are equal, the full flag tells a full queue from an empty one. A sticky pending bit raises the interrupt line whenever the queue holds data and the not-empty source is unmasked. Software clears the pending bit by writing one to it. A register that reads back as the depth minus one lets software learn the queue size. Writing zero to a clear register puts the queue back to its empty state.

Top module: `mbx_rx_queue`

## Requirements
- R1: After reset both positions are 0, the full flag is 0, the pending bit and `irq` are 0, `in_ready` is 1, and the mask register (offset 0x1C, bits [4:0]) reads 5'h1F.
- R2: A message is accepted on a cycle with `in_valid` and `in_ready` both high. It is stored at the write position, and the write position then advances by one, wrapping from `DEPTH-1` to 0.
- R3: A read is requested by holding `reg_rd` high for one cycle, and `reg_rdata` holds the result from the following cycle. For the oldest entry, offset 0x4 returns payload bits [31:0], offset 0x8 returns payload bits [63:32], and offset 0x0 returns the channel number in bits [2:0] with the upper bits zero.
- R4: Writing a value with bit 0 set to offset 0xC pops one entry and advances the read position by one, modulo `DEPTH`. The same write has no effect on an empty queue.
- R5: The status word at offset 0x14 holds the read position in bits [31:24], the write position in bits [23:16] and the full flag in bit 2. All its other bits are 0.
- R6: The full flag sets when an accepted message makes the write position equal to the read position. `in_ready` is low while the flag is set, so any message offered then is refused. Any pop clears the flag.
- R7: Offset 0x24 reads as `DEPTH-1`.
- R8: Writing 0 to offset 0x10 returns both positions to 0 and clears the full flag and the pending bit. A non-zero value written there has no effect.
- R9: While the queue is non-empty and mask bit 0 is clear, the pending bit is set on the next clock edge. The pending bit is visible at bit 0 of offset 0x18 and drives `irq`. Once set, it stays set until it is cleared.
- R10: Writing a value with bit 0 set to offset 0x18 clears the pending bit. If the queue is still non-empty and unmasked, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A sender offers a message |
| in_ready | output | 1 | The queue can accept a message this cycle |
| in_payload | input | 64 | Message payload |
| in_chan | input | 3 | Source channel number |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 6 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the read strobe |
| irq | output | 1 | Not-empty interrupt |

## Verification
The assertions assume that the register strobes arrive as single-cycle pulses and that `reset` holds for at least one clock edge. They also assume that senders keep a refused message offered, although nothing in the checks depends on that. The pointer checks take for granted that a pop and a queue clear never need to land together with an accepted message in a way that would be ambiguous. The bench keeps to this: it issues each register access on its own, with the input port idle, and it offers messages only between accesses. Random pushes are allowed to hit a full queue, so refusals are exercised inside these bounds.

// File: rtl/mbx_rx_pkg.sv
`timescale 1ns/1ps
package mbx_rx_pkg;
  localparam int MSG_W  = 64;
  localparam int CHAN_W = 3;
  localparam int ADDR_W = 6;
  localparam int POS_W  = 8;  // width of a position field in the status word
  localparam int MASK_W = 5;

  localparam logic [ADDR_W-1:0] OFS_CHAN   = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_LOW    = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_HIGH   = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_POP    = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_CLEAR  = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_PEND   = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_MASK   = 6'h1C;
  localparam logic [ADDR_W-1:0] OFS_DEPTH  = 6'h24;

  typedef struct packed {
    logic [CHAN_W-1:0] chan;
    logic [MSG_W-1:0]  payload;
  } msg_t;
endpackage

// File: rtl/mbx_rx_store.sv
`timescale 1ns/1ps
module mbx_rx_store
  import mbx_rx_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [PW-1:0] waddr,
  input  msg_t          wdata,
  input  logic [PW-1:0] raddr,
  output msg_t          rdata
);
  // Synchronous write with an asynchronous read port.
  // The head entry is visible without waiting a cycle.
  msg_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/mbx_rx_ptrs.sv
`timescale 1ns/1ps
module mbx_rx_ptrs #(
  parameter int DEPTH = 8,
  parameter int PW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_req,
  input  logic          pop_req,
  input  logic          clr,
  output logic          push,
  output logic          pop,
  output logic [PW-1:0] wr_ptr,
  output logic [PW-1:0] rd_ptr,
  output logic          full,
  output logic          empty
);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  logic [PW-1:0] wr_nxt, rd_nxt;

  assign empty  = (wr_ptr == rd_ptr) && !full;
  assign push   = push_req && !full;
  assign pop    = pop_req && !empty;
  assign wr_nxt = step(wr_ptr);
  assign rd_nxt = step(rd_ptr);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      full   <= 1'b0;
    end else begin
      if (push) wr_ptr <= wr_nxt;
      if (pop)  rd_ptr <= rd_nxt;
      if (pop)
        full <= 1'b0;
      else if (push && (wr_nxt == rd_ptr))
        full <= 1'b1;
    end
  end

  // R2
  wr_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (push && !clr) |=> wr_ptr == (($past(wr_ptr) == LAST) ? '0 : $past(wr_ptr) + 1'b1));
  // R6
  full_equal_chk: assert property (@(posedge clk) disable iff (rst)
    full |-> (wr_ptr == rd_ptr));
  // R6
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (full && !pop_req && !clr) |=> full);
  // R4
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (pop_req && empty && !push_req && !clr) |=> $stable(rd_ptr) && $stable(wr_ptr));
  // R8
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (wr_ptr == '0) && (rd_ptr == '0) && !full);
endmodule

// File: rtl/mbx_rx_irq.sv
`timescale 1ns/1ps
module mbx_rx_irq
  import mbx_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              nonempty,
  input  logic              mask_we,
  input  logic [MASK_W-1:0] mask_wdata,
  input  logic              ack,
  input  logic              clr,
  output logic [MASK_W-1:0] mask,
  output logic              pend
);
  logic src_on;
  assign src_on = nonempty && !mask[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      mask <= '1;
      pend <= 1'b0;
    end else begin
      if (mask_we) mask <= mask_wdata;
      if (clr)
        pend <= 1'b0;
      else
        pend <= (pend && !ack) || src_on;
    end
  end

  // R9
  pend_set_chk: assert property (@(posedge clk) disable iff (rst)
    (src_on && !clr) |=> pend);
  // R10
  pend_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && !src_on) |=> !pend);
  // R9
  pend_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (pend && !ack && !clr) |=> pend);
endmodule

// File: rtl/mbx_rx_queue.sv
`timescale 1ns/1ps
module mbx_rx_queue
  import mbx_rx_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [MSG_W-1:0]  in_payload,
  input  logic [CHAN_W-1:0] in_chan,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic          push, pop, full, empty, clr, pop_req, ack, mask_we;
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [MASK_W-1:0] mask;
  logic          pend;
  msg_t          head, wmsg;

  assign pop_req = reg_wr && (reg_addr == OFS_POP) && reg_wdata[0];
  assign clr     = reg_wr && (reg_addr == OFS_CLEAR) && (reg_wdata == '0);
  assign ack     = reg_wr && (reg_addr == OFS_PEND) && reg_wdata[0];
  assign mask_we = reg_wr && (reg_addr == OFS_MASK);
  assign wmsg    = '{chan: in_chan, payload: in_payload};

  mbx_rx_ptrs #(.DEPTH(DEPTH), .PW(PW)) u_ptrs (
    .clk(clk), .rst(rst), .push_req(in_valid), .pop_req(pop_req), .clr(clr),
    .push(push), .pop(pop), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .full(full), .empty(empty)
  );

  mbx_rx_store #(.DEPTH(DEPTH), .PW(PW)) u_store (
    .clk(clk), .we(push), .waddr(wr_ptr), .wdata(wmsg),
    .raddr(rd_ptr), .rdata(head)
  );

  mbx_rx_irq u_irq (
    .clk(clk), .rst(rst), .nonempty(!empty), .mask_we(mask_we),
    .mask_wdata(reg_wdata[MASK_W-1:0]), .ack(ack), .clr(clr),
    .mask(mask), .pend(pend)
  );

  assign in_ready = !full;
  assign irq      = pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        OFS_CHAN:   reg_rdata <= 32'(head.chan);
        OFS_LOW:    reg_rdata <= head.payload[31:0];
        OFS_HIGH:   reg_rdata <= head.payload[63:32];
        OFS_STATUS: reg_rdata <= {POS_W'(rd_ptr), POS_W'(wr_ptr), 13'b0, full, 2'b0};
        OFS_PEND:   reg_rdata <= 32'(pend);
        OFS_MASK:   reg_rdata <= 32'(mask);
        OFS_DEPTH:  reg_rdata <= 32'(DEPTH - 1);
        default:    reg_rdata <= '0;
      endcase
    end
  end

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_ready) |=> $stable(wr_ptr) || $past(clr));
  // R3
  rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> $stable(reg_rdata));
endmodule

// File: tb/tb_mbx_rx_queue.sv
`timescale 1ns/1ps
module tb_mbx_rx_queue;
  localparam int DEPTH = 8;
  localparam real TCK = 5.0;

  logic clk = 0, rst = 1;
  logic in_valid = 0, reg_wr = 0, reg_rd = 0;
  logic [63:0] in_payload = '0;
  logic [2:0]  in_chan = '0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  wire         in_ready, irq;
  wire  [31:0] reg_rdata;

  mbx_rx_queue #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_payload(in_payload), .in_chan(in_chan), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  always #(TCK/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model
  logic [63:0] m_pay [DEPTH];
  logic [2:0]  m_ch  [DEPTH];
  int m_wr = 0, m_rd = 0;
  bit m_full = 0;

  function automatic bit m_empty();
    return (m_wr == m_rd) && !m_full;
  endfunction

  function automatic logic [31:0] exp_status();
    return {8'(m_rd), 8'(m_wr), 13'b0, m_full, 2'b0};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd_reg(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1; reg_addr = a;
    @(negedge clk);
    reg_rd = 0;
    d = reg_rdata;
  endtask

  task automatic push(input logic [63:0] p, input logic [2:0] c);
    bit acc;
    @(negedge clk);
    in_valid = 1; in_payload = p; in_chan = c;
    acc = !m_full;
    chk(in_ready == acc, "R6 in_ready", 64'(in_ready), 64'(acc));
    @(negedge clk);
    in_valid = 0;
    if (acc) begin
      m_pay[m_wr] = p; m_ch[m_wr] = c;
      m_wr = (m_wr + 1) % DEPTH;
      if (m_wr == m_rd) m_full = 1;
    end
  endtask

  task automatic pop();
    wr_reg(6'h0C, 32'h1);
    if (!m_empty()) begin
      m_rd = (m_rd + 1) % DEPTH;
      m_full = 0;
    end
  endtask

  task automatic check_status(input string req);
    logic [31:0] d;
    rd_reg(6'h14, d);
    chk(d == exp_status(), req, 64'(d), 64'(exp_status()));
  endtask

  task automatic check_head(input string req);
    logic [31:0] lo, hi, ch;
    rd_reg(6'h04, lo);
    rd_reg(6'h08, hi);
    rd_reg(6'h00, ch);
    chk({hi, lo} == m_pay[m_rd], req, {hi, lo}, m_pay[m_rd]);
    chk(ch == 32'(m_ch[m_rd]), req, 64'(ch), 64'(m_ch[m_rd]));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(TCK * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state
    chk(in_ready == 1, "R1 in_ready", 64'(in_ready), 1);
    chk(irq == 0, "R1 irq", 64'(irq), 0);
    check_status("R1 status");
    rd_reg(6'h1C, d);
    chk(d == 32'h1F, "R1 mask", 64'(d), 64'h1F);
    rd_reg(6'h18, d);
    chk(d == 0, "R1 pending", 64'(d), 0);

    // R7 depth register
    rd_reg(6'h24, d);
    chk(d == DEPTH - 1, "R7 depth", 64'(d), 64'(DEPTH - 1));

    // R4 pop on empty queue has no effect
    pop();
    check_status("R4 empty pop");

    // R2 R3 R5 R6 fill to full, refuse one, wrap
    for (int i = 0; i < DEPTH; i++) push(64'hA5A5_0000_0000_0000 + 64'(i), 3'(i));
    check_status("R6 full flag");
    check_head("R3 head after fill");
    push(64'hDEAD_BEEF_0000_0001, 3'd7);
    check_status("R6 refused push");
    pop();
    check_status("R6 pop clears full");
    check_head("R3 head after pop");
    push(64'h1234_5678_9ABC_DEF0, 3'd5);
    check_status("R2 wrap write position");

    // R9 masked source keeps irq low
    repeat (2) @(negedge clk);
    chk(irq == 0, "R9 masked", 64'(irq), 0);
    wr_reg(6'h1C, 32'h1E);
    @(negedge clk);
    chk(irq == 1, "R9 irq raised", 64'(irq), 1);
    rd_reg(6'h18, d);
    chk(d == 1, "R9 pending bit", 64'(d), 1);

    // R10 clear while still non-empty leaves it set
    wr_reg(6'h18, 32'h1);
    @(negedge clk);
    chk(irq == 1, "R10 clear while non-empty", 64'(irq), 1);

    // R8 non-zero write to the clear register is ignored
    wr_reg(6'h10, 32'h5);
    check_status("R8 nonzero ignored");

    // drain; pending stays sticky, then clear it
    while (!m_empty()) begin
      check_head("R3 drain");
      pop();
    end
    check_status("R4 drained");
    @(negedge clk);
    chk(irq == 1, "R9 sticky after drain", 64'(irq), 1);
    wr_reg(6'h18, 32'h1);
    @(negedge clk);
    chk(irq == 0, "R10 clear after drain", 64'(irq), 0);

    // R8 zero clears pointers and pending
    push(64'h1, 3'd1);
    push(64'h2, 3'd2);
    @(negedge clk);
    chk(irq == 1, "R9 re-raise", 64'(irq), 1);
    wr_reg(6'h10, 32'h0);
    m_wr = 0; m_rd = 0; m_full = 0;
    check_status("R8 clear pointers");
    chk(irq == 0, "R8 clear pending", 64'(irq), 0);

    // random mix
    for (int i = 0; i < 600; i++) begin
      int op;
      op = int'($urandom % 10);
      if (op < 5)
        push({$urandom, $urandom}, 3'($urandom));
      else if (op < 8)
        pop();
      else if (op == 8)
        check_status("R5 random status");
      else if (!m_empty())
        check_head("R3 random head");
    end
    check_status("R5 final status");

    finish_run();
  end
endmodule